// File: doc/BRIEF.md
# Supply Voltage Supervisor Control

This block is the digital side of a supply-voltage monitor. A small register file holds the supervisor setup: an enable, a choice of which analog comparator to watch, a choice of what to do on a detection, and a threshold code. The threshold code drives an external comparator bank. The block watches the chosen comparator output, which is 1 while the watched voltage is below its threshold. When that output goes from above to below, the block raises either a sticky interrupt request or an internal reset request. The comparator output passes through a synchronizer first.

After the supervisor is enabled, a stabilization timer blanks all results until the analog path has settled. While the supervisor is on, the source, action and threshold settings are locked. A write that tries to change them is dropped and sets a sticky error bit.

The chip answers a reset request by pulsing the system reset. A system reset that this block asked for keeps the enable, source, action and threshold settings. Start-up code can therefore see the enable bit still set and skip setup. Any other system reset clears those settings. A power-on reset clears everything.

Top module: `lvd_ctrl`

## Requirements
- R1: After power-on reset, every register reads 0, and `lvl_sel`, `mon_en`, `irq_o` and `rst_req` are 0.
- R2: A write to address 0 is always accepted: bit 0 is the enable and bit 1 is the interrupt-output enable. Both read back at address 0, and `mon_en` follows the enable bit.
- R3: While the enable bit is 0, writes are accepted at two addresses. At address 1, bit 0 selects the source (0 = supply comparator, 1 = external-pin comparator) and bit 1 selects the action (0 = interrupt, 1 = reset). At address 2, bits 3:0 hold the threshold code, which appears on `lvl_sel`. Both registers read back.
- R4: While the enable bit is 1, writes to address 1 or 2 leave both registers unchanged and set the write-error bit (status bit 3). Writing 1 to status bit 3 clears it.
- R5: For STAB_CYCLES cycles after the enable becomes 1, no detection is made and the detection flag reads 0. The ready bit (status bit 1) then reads 1.
- R6: The detection flag (status bit 0) reads 1 while the enable and ready bits are both 1 and the selected comparator reports below threshold. Otherwise it reads 0. The comparator that is not selected has no effect.
- R7: Only an above-to-below transition of the selected comparator triggers. Staying below, going back above, or already being below when ready goes to 1 does not trigger.
- R8: With action 0, a trigger sets the pending bit (status bit 2). The pending bit stays set until a 1 is written to status bit 2. `irq_o` equals the pending bit gated by the interrupt-output enable.
- R9: With action 1, a trigger raises `rst_req` and does not set the pending bit. `rst_req` stays high until `sys_rst_n` is low.
- R10: A system reset that follows a raised `rst_req` keeps the enable, source, action and threshold settings. Any other system reset clears them. Every system reset clears the pending bit, the write-error bit and the interrupt-output enable, and restarts the stabilization wait.
- R11: While the enable bit is 0, comparator activity sets no pending bit and no reset request, and the detection flag reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears everything |
| sys_rst_n | input | 1 | Synchronous system reset, active low; settings kept only after a self-requested reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control, 1 mode, 2 threshold, 3 status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| vdd_below | input | 1 | Supply comparator output, 1 = below the selected threshold |
| ext_below | input | 1 | External-pin comparator output, 1 = below its fixed threshold |
| lvl_sel | output | 4 | Threshold code to the comparator bank |
| mon_en | output | 1 | Comparator bank enable |
| irq_o | output | 1 | Interrupt request |
| rst_req | output | 1 | Internal reset request |

## Verification
The bench tries to change the locked settings with random data while the supervisor is enabled. A guard that leaks would show a changed threshold on `lvl_sel` or in readback. The bench places a below pulse inside the blanking window. A timer that is too short, or an edge detector that loses track while blanked, would raise a false request there. It also enables with the comparator already below threshold, holds it below across an interrupt clear, and toggles the comparator that is not selected. Each of these shows whether only a true above-to-below crossing on the chosen source fires. Finally, it runs a system reset both after a self-requested reset and without one. A design that ignored the cause would either lose the setup or keep stale settings.

// File: rtl/lvd_pkg.sv
package lvd_pkg;

   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      A_CTRL  = 2'd0,
      A_MODE  = 2'd1,
      A_LEVEL = 2'd2,
      A_STAT  = 2'd3
   } reg_addr_e;

   // control register bits
   localparam int B_EN     = 0;
   localparam int B_IRQEN  = 1;
   // mode register bits
   localparam int B_SRC    = 0;
   localparam int B_ACT    = 1;
   // status register bits
   localparam int B_FLAG   = 0;
   localparam int B_READY  = 1;
   localparam int B_PEND   = 2;
   localparam int B_WERR   = 3;

endpackage

// File: rtl/lvd_stab.sv
module lvd_stab #(
   parameter int STAB_CYCLES = 40
) (
   input  logic clk,
   input  logic por_n,
   input  logic clr,
   output logic ready
);
   localparam int CW = $clog2(STAB_CYCLES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(STAB_CYCLES);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)             cnt_q <= '0;
      else if (clr)           cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
   end

   assign ready = (cnt_q == LIMIT);
endmodule

// File: rtl/lvd_detect.sv
module lvd_detect #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic sys_rst_n,
   input  logic vdd_below,
   input  logic ext_below,
   input  logic src_ext,
   input  logic act_rst,
   input  logic en,
   input  logic ready,
   output logic below_s,
   output logic pend_set,
   output logic rst_req
);
   localparam int LAST = SYNC_STAGES - 1;

   logic                   sel_raw;
   logic [SYNC_STAGES-1:0] chain_q;
   logic                   prev_q;
   logic                   rreq_q;
   logic                   fire;

   assign sel_raw = src_ext ? ext_below : vdd_below;

   generate
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
         logic d_in;
         if (i == 0) begin : g_head
            assign d_in = sel_raw;
         end else begin : g_tail
            assign d_in = chain_q[i-1];
         end
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)          chain_q[i] <= 1'b0;
            else if (!sys_rst_n) chain_q[i] <= 1'b0;
            else                 chain_q[i] <= d_in;
         end
      end
   endgenerate

   assign below_s = chain_q[LAST];
   assign fire    = en & ready & below_s & ~prev_q & ~rreq_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         prev_q <= 1'b0;
         rreq_q <= 1'b0;
      end else if (!sys_rst_n) begin
         prev_q <= 1'b0;
         rreq_q <= 1'b0;
      end else begin
         prev_q <= below_s;
         if (fire && act_rst) rreq_q <= 1'b1;
      end
   end

   assign pend_set = fire & ~act_rst;
   assign rst_req  = rreq_q;
endmodule

// File: rtl/lvd_regs.sv
module lvd_regs
   import lvd_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int LEVEL_W = 4
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               sys_rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic               det_rst,
   input  logic               pend_set,
   output logic               en,
   output logic               irq_en,
   output logic               src_ext,
   output logic               act_rst,
   output logic [LEVEL_W-1:0] level,
   output logic               irq_pend,
   output logic               wr_err
);
   logic hold_q;
   logic keep_cfg;

   assign keep_cfg = hold_q | det_rst;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         hold_q   <= 1'b0;
         en       <= 1'b0;
         irq_en   <= 1'b0;
         src_ext  <= 1'b0;
         act_rst  <= 1'b0;
         level    <= '0;
         irq_pend <= 1'b0;
         wr_err   <= 1'b0;
      end else if (!sys_rst_n) begin
         hold_q   <= keep_cfg;
         irq_en   <= 1'b0;
         irq_pend <= 1'b0;
         wr_err   <= 1'b0;
         if (!keep_cfg) begin
            en      <= 1'b0;
            src_ext <= 1'b0;
            act_rst <= 1'b0;
            level   <= '0;
         end
      end else begin
         hold_q <= 1'b0;
         if (wr_en) begin
            case (reg_addr_e'(addr))
               A_CTRL: begin
                  en     <= wdata[B_EN];
                  irq_en <= wdata[B_IRQEN];
               end
               A_MODE: begin
                  if (en) wr_err <= 1'b1;
                  else begin
                     src_ext <= wdata[B_SRC];
                     act_rst <= wdata[B_ACT];
                  end
               end
               A_LEVEL: begin
                  if (en) wr_err <= 1'b1;
                  else    level  <= wdata[LEVEL_W-1:0];
               end
               A_STAT: begin
                  if (wdata[B_PEND]) irq_pend <= 1'b0;
                  if (wdata[B_WERR]) wr_err   <= 1'b0;
               end
               default: ;
            endcase
         end
         if (pend_set) irq_pend <= 1'b1;
      end
   end
endmodule

// File: rtl/lvd_ctrl.sv
module lvd_ctrl
   import lvd_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int LEVEL_W     = 4,
   parameter int SYNC_STAGES = 2,
   parameter int STAB_CYCLES = 40
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               sys_rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   input  logic               vdd_below,
   input  logic               ext_below,
   output logic [LEVEL_W-1:0] lvl_sel,
   output logic               mon_en,
   output logic               irq_o,
   output logic               rst_req
);
   generate
      if (DATA_W < 4 || LEVEL_W > DATA_W) begin : g_bad_width
         $error("lvd_ctrl: DATA_W must be >= 4 and >= LEVEL_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("lvd_ctrl: SYNC_STAGES must be at least 2");
      end
      if (STAB_CYCLES < 1) begin : g_bad_stab
         $error("lvd_ctrl: STAB_CYCLES must be at least 1");
      end
   endgenerate

   logic               en, irq_en, src_ext, act_rst;
   logic [LEVEL_W-1:0] level;
   logic               irq_pend, wr_err;
   logic               ready, below_s, pend_set, det_rst;
   logic               stab_clr;
   logic               det_flag;

   lvd_regs #(.DATA_W(DATA_W), .LEVEL_W(LEVEL_W)) u_regs (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
      .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .det_rst(det_rst), .pend_set(pend_set),
      .en(en), .irq_en(irq_en), .src_ext(src_ext), .act_rst(act_rst),
      .level(level), .irq_pend(irq_pend), .wr_err(wr_err)
   );

   assign stab_clr = ~sys_rst_n | ~en;

   lvd_stab #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
      .clk(clk), .por_n(por_n), .clr(stab_clr), .ready(ready)
   );

   lvd_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
      .vdd_below(vdd_below), .ext_below(ext_below),
      .src_ext(src_ext), .act_rst(act_rst), .en(en), .ready(ready),
      .below_s(below_s), .pend_set(pend_set), .rst_req(det_rst)
   );

   assign det_flag = en & ready & below_s;

   always_comb begin
      rdata = '0;
      case (reg_addr_e'(addr))
         A_CTRL: begin
            rdata[B_EN]    = en;
            rdata[B_IRQEN] = irq_en;
         end
         A_MODE: begin
            rdata[B_SRC] = src_ext;
            rdata[B_ACT] = act_rst;
         end
         A_LEVEL: rdata[LEVEL_W-1:0] = level;
         A_STAT: begin
            rdata[B_FLAG]  = det_flag;
            rdata[B_READY] = ready;
            rdata[B_PEND]  = irq_pend;
            rdata[B_WERR]  = wr_err;
         end
         default: rdata = '0;
      endcase
   end

   assign lvl_sel = level;
   assign mon_en  = en;
   assign irq_o   = irq_pend & irq_en;
   assign rst_req = det_rst;
endmodule

// File: rtl/lvd_ctrl_chk.sv
module lvd_ctrl_chk #(
   parameter int DATA_W  = 8,
   parameter int LEVEL_W = 4
) (
   input logic               clk,
   input logic               por_n,
   input logic               sys_rst_n,
   input logic               wr_en,
   input logic [1:0]         addr,
   input logic [DATA_W-1:0]  wdata,
   input logic               en,
   input logic               src_ext,
   input logic               act_rst,
   input logic [LEVEL_W-1:0] level,
   input logic               ready,
   input logic               irq_pend,
   input logic               wr_err,
   input logic               rst_req
);
   // R4
   rej_keep_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      (wr_en && en && (addr == 2'd1 || addr == 2'd2))
      |=> ($stable(level) && $stable(src_ext) && $stable(act_rst)));

   // R4
   rej_err_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      (wr_en && en && (addr == 2'd1 || addr == 2'd2)) |=> wr_err);

   // R5
   stab_quiet_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      !ready |=> (!$rose(irq_pend) && !$rose(rst_req)));

   // R11
   off_quiet_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      !en |=> (!$rose(irq_pend) && !$rose(rst_req)));

   // R8
   pend_hold_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      (irq_pend && !(wr_en && addr == 2'd3 && wdata[2])) |=> irq_pend);

   // R8
   irq_route_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      $rose(irq_pend) |-> !act_rst);

   // R9
   rst_route_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      $rose(rst_req) |-> (act_rst && en && !irq_pend));

   // R9
   rst_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (rst_req && sys_rst_n) |=> rst_req);

   // R10
   keep_cfg_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!sys_rst_n && rst_req) |=> (en && $stable(level)));
endmodule

bind lvd_ctrl lvd_ctrl_chk #(.DATA_W(DATA_W), .LEVEL_W(LEVEL_W)) u_chk (
   .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
   .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .en(en), .src_ext(src_ext), .act_rst(act_rst), .level(level),
   .ready(ready), .irq_pend(irq_pend), .wr_err(wr_err), .rst_req(det_rst)
);

// File: tb/tb_lvd_ctrl.sv
module tb_lvd_ctrl;
   localparam int STAB = 40;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       sys_rst_n = 1'b1;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       vdd_below = 1'b0;
   logic       ext_below = 1'b0;
   logic [3:0] lvl_sel;
   logic       mon_en, irq_o, rst_req;

   int total = 0;
   int bad = 0;
   logic [3:0] exp_lvl;

   always #4 clk = ~clk;

   lvd_ctrl #(.STAB_CYCLES(STAB)) dut (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .vdd_below(vdd_below), .ext_below(ext_below),
      .lvl_sel(lvl_sel), .mon_en(mon_en), .irq_o(irq_o), .rst_req(rst_req)
   );

   // expected status word from the requirement encoding
   function automatic logic [7:0] stat_word(input logic flag, input logic rdy,
                                            input logic pend, input logic err);
      return {4'b0000, err, pend, rdy, flag};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      int unsigned seed;
      seed = $urandom(32'd2024);

      idle(3);
      por_n = 1'b1;
      idle(2);
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         chk("R1 reg", v, 0);
      end
      chk("R1 lvl_sel", lvl_sel, 0);
      chk("R1 mon_en", mon_en, 0);
      chk("R1 irq_o", irq_o, 0);
      chk("R1 rst_req", rst_req, 0);

      // R3 configure while disabled
      wr(2'd2, 8'h0A);
      wr(2'd1, 8'h00);
      rd(2'd2, v); chk("R3 level readback", v, 8'h0A);
      chk("R3 lvl_sel", lvl_sel, 4'hA);
      for (int i = 0; i < 8; i++) begin
         exp_lvl = 4'($urandom);
         wr(2'd2, {4'($urandom), exp_lvl});
         rd(2'd2, v); chk("R3 random level", v, exp_lvl);
      end
      wr(2'd2, 8'h0A);

      // R2 enable with interrupt output on
      wr(2'd0, 8'h03);
      rd(2'd0, v); chk("R2 ctrl readback", v, 8'h03);
      chk("R2 mon_en", mon_en, 1);

      // R5 below pulse inside blanking window
      vdd_below = 1'b1;
      idle(5);
      rd(2'd3, v); chk("R5 blanked status", v, stat_word(0, 0, 0, 0));
      vdd_below = 1'b0;
      idle(STAB + 5);
      rd(2'd3, v); chk("R5 ready after wait", v, stat_word(0, 1, 0, 0));
      chk("R5 no irq", irq_o, 0);

      // R4 locked writes while enabled
      for (int i = 0; i < 6; i++) begin
         wr(($urandom % 2 == 0) ? 2'd1 : 2'd2, 8'($urandom));
         rd(2'd2, v); chk("R4 level locked", v, 8'h0A);
         rd(2'd1, v); chk("R4 mode locked", v, 8'h00);
      end
      rd(2'd3, v); chk("R4 wr_err set", v, stat_word(0, 1, 0, 1));
      wr(2'd3, 8'h08);
      rd(2'd3, v); chk("R4 wr_err cleared", v, stat_word(0, 1, 0, 0));

      // R6 R7 R8 supply falling crossing
      ext_below = 1'b1;
      idle(4);
      rd(2'd3, v); chk("R6 unselected source ignored", v, stat_word(0, 1, 0, 0));
      ext_below = 1'b0;
      vdd_below = 1'b1;
      idle(4);
      rd(2'd3, v); chk("R8 pending after crossing", v, stat_word(1, 1, 1, 0));
      chk("R8 irq_o", irq_o, 1);
      chk("R9 no reset for irq action", rst_req, 0);
      wr(2'd3, 8'h04);
      idle(4);
      rd(2'd3, v); chk("R7 staying below no retrigger", v, stat_word(1, 1, 0, 0));
      vdd_below = 1'b0;
      idle(4);
      rd(2'd3, v); chk("R7 rising no trigger", v, stat_word(0, 1, 0, 0));
      wr(2'd0, 8'h01);
      vdd_below = 1'b1;
      idle(4);
      rd(2'd3, v); chk("R8 masked pend", v, stat_word(1, 1, 1, 0));
      chk("R8 masked irq_o", irq_o, 0);
      wr(2'd0, 8'h03);
      chk("R8 unmasked irq_o", irq_o, 1);
      wr(2'd3, 8'h04);
      vdd_below = 1'b0;

      // R11 disabled
      wr(2'd0, 8'h02);
      idle(3);
      vdd_below = 1'b1; idle(4);
      rd(2'd3, v); chk("R11 flag off", v, stat_word(0, 0, 0, 0));
      vdd_below = 1'b0; idle(4);
      rd(2'd3, v); chk("R11 no pend", v, 0);

      // R6 external source
      wr(2'd1, 8'h01);
      wr(2'd0, 8'h03);
      idle(STAB + 5);
      vdd_below = 1'b1; idle(4);
      rd(2'd3, v); chk("R6 supply ignored on ext", v, stat_word(0, 1, 0, 0));
      vdd_below = 1'b0;
      ext_below = 1'b1; idle(4);
      rd(2'd3, v); chk("R6 ext crossing", v, stat_word(1, 1, 1, 0));
      wr(2'd3, 8'h04);
      ext_below = 1'b0;

      // R7 already below when ready
      wr(2'd0, 8'h00);
      ext_below = 1'b1;
      idle(4);
      wr(2'd0, 8'h03);
      idle(STAB + 5);
      rd(2'd3, v); chk("R7 below at ready", v, stat_word(1, 1, 0, 0));
      ext_below = 1'b0;
      wr(2'd0, 8'h00);

      // R9 reset action
      wr(2'd1, 8'h03);
      wr(2'd2, 8'h07);
      wr(2'd0, 8'h03);
      idle(STAB + 5);
      ext_below = 1'b1; idle(4);
      chk("R9 rst_req raised", rst_req, 1);
      rd(2'd3, v); chk("R9 no pend", v[2], 0);
      idle(10);
      chk("R9 rst_req held", rst_req, 1);
      ext_below = 1'b0;
      sys_rst_n = 1'b0; idle(3);
      sys_rst_n = 1'b1; idle(1);
      // R10 self-requested reset keeps setup
      chk("R10 rst_req dropped", rst_req, 0);
      rd(2'd0, v); chk("R10 enable kept", v, 8'h01);
      rd(2'd1, v); chk("R10 mode kept", v, 8'h03);
      rd(2'd2, v); chk("R10 level kept", v, 8'h07);
      rd(2'd3, v); chk("R10 stab restarted", v, 0);

      // R10 other reset clears setup
      sys_rst_n = 1'b0; idle(3);
      sys_rst_n = 1'b1; idle(1);
      rd(2'd0, v); chk("R10 enable cleared", v, 0);
      rd(2'd1, v); chk("R10 mode cleared", v, 0);
      rd(2'd2, v); chk("R10 level cleared", v, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule